// File: doc/BRIEF.md
# Bus-Cycle-Aligned E Clock and Valid-Address Generator

This block produces a slow, synchronous peripheral clock (E) and an active-low valid-memory-address strobe from an 8 MHz reference clock. A fast processor can use them to reach older synchronous peripherals, such as serial ACIAs, that expect a 6800-style bus. The phase counter that shapes E does not run freely. It is held cleared whenever reset is active or the processor's address strobe is negated, so every bus cycle starts E from the same phase.

When the processor signals a slow-peripheral access by pulling its peripheral-request input low, the block samples that input once per E period, late in the low phase. If the input is low at that point, it asserts the valid-address output until E falls. Data transfer and acknowledge generation are handled elsewhere.

Top module: `eclk_vma_gen`

## Requirements
- R1: While `rstN` is low, `eClk` is 0 and `vmaN` is 1, whatever the clock does.
- R2: While `asN` is high, `eClk` is 0 and `vmaN` is 1. The clear is asynchronous, so the outputs follow within the same clock period without a clock edge.
- R3: While `asN` is held low, `eClk` repeats with a period of 10 clocks: 6 clocks low, then 4 clocks high.
- R4: Count rising edges from the first edge at which `asN` is low. `eClk` goes high after edge 6 and goes low after edge 10. The count restarts at 1 after every negation of `asN`.
- R5: If `vpaN` is low at edge 3 of a period, `vmaN` goes low after that edge. It stays low through the E-high phase and returns high after the edge at which `eClk` falls (edge 10).
- R6: `vpaN` is sampled only at edge 3 of each period. Its value at any other edge has no effect on `vmaN`. If it is high at edge 3, `vmaN` stays high for the whole period.
- R7: Raising `asN` while `eClk` is high and `vmaN` is low forces `eClk` to 0 and `vmaN` to 1 at once.
- R8: Each period evaluates `vpaN` on its own. A previous period's assertion of `vmaN` does not carry over into the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 8 MHz reference clock |
| rstN | input | 1 | Active-low reset, asynchronous clear |
| asN | input | 1 | Active-low processor address strobe; high clears the phase counter |
| vpaN | input | 1 | Active-low request for a slow-peripheral access |
| eClk | output | 1 | Peripheral E clock |
| vmaN | output | 1 | Active-low valid-memory-address strobe |

## Verification
The assertions assume that `asN` and `rstN` change away from the rising clock edge. They also assume that `vpaN` is a settled, synchronous level at each edge, because the clear is asynchronous and the request input is sampled with no synchronizer. The bench drives every input one nanosecond after a rising edge, and samples outputs just before the next change. Asynchronous clears are checked with no clock edge between the stimulus and the sample.

// File: rtl/eclk_pkg.sv
package eclk_pkg;
  // Phase strobes sent from the phase counter to the output registers.
  typedef struct packed {
    logic eRise;   // last E-low state: E goes high at the next edge
    logic eFall;   // last E-high state: E goes low at the next edge
    logic vmaArm;  // request-sampling state
  } phaseStrobes_t;
endpackage

// File: rtl/eclk_phase_ctrl.sv
module eclk_phase_ctrl
  import eclk_pkg::*;
#(
  parameter int LOW_CYCLES    = 6,
  parameter int HIGH_CYCLES   = 4,
  parameter int VMA_ARM_STATE = 2
) (
  input  logic          clk,
  input  logic          clrN,
  output phaseStrobes_t strobes
);
  localparam int PERIOD = LOW_CYCLES + HIGH_CYCLES;
  localparam int CW     = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST_STATE = CW'(PERIOD - 1);
  localparam logic [CW-1:0] RISE_STATE = CW'(LOW_CYCLES - 1);
  localparam logic [CW-1:0] ARM_STATE  = CW'(VMA_ARM_STATE);

  logic [CW-1:0] phaseQ;

  // The phase flops clear asynchronously, so E restarts with each bus cycle.
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)                    phaseQ <= '0;
    else if (phaseQ == LAST_STATE) phaseQ <= '0;
    else                          phaseQ <= phaseQ + 1'b1;
  end

  always_comb begin
    strobes.eRise  = (phaseQ == RISE_STATE);
    strobes.eFall  = (phaseQ == LAST_STATE);
    strobes.vmaArm = (phaseQ == ARM_STATE);
  end
endmodule

// File: rtl/eclk_out_path.sv
module eclk_out_path
  import eclk_pkg::*;
(
  input  logic          clk,
  input  logic          clrN,
  input  logic          vpaN,
  input  phaseStrobes_t strobes,
  output logic          eClk,
  output logic          vmaN
);
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)              eClk <= 1'b0;
    else if (strobes.eRise) eClk <= 1'b1;
    else if (strobes.eFall) eClk <= 1'b0;
  end

  // VMA is armed once per period and released together with the fall of E.
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)                         vmaN <= 1'b1;
    else if (strobes.eFall)            vmaN <= 1'b1;
    else if (strobes.vmaArm && !vpaN)  vmaN <= 1'b0;
  end
endmodule

// File: rtl/eclk_vma_gen.sv
module eclk_vma_gen
  import eclk_pkg::*;
#(
  parameter int LOW_CYCLES    = 6,
  parameter int HIGH_CYCLES   = 4,
  parameter int VMA_ARM_STATE = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asN,
  input  logic vpaN,
  output logic eClk,
  output logic vmaN
);
  logic          clrN;
  phaseStrobes_t strobes;

  assign clrN = rstN & ~asN;

  eclk_phase_ctrl #(
    .LOW_CYCLES   (LOW_CYCLES),
    .HIGH_CYCLES  (HIGH_CYCLES),
    .VMA_ARM_STATE(VMA_ARM_STATE)
  ) ctrl (
    .clk    (clk),
    .clrN   (clrN),
    .strobes(strobes)
  );

  eclk_out_path path (
    .clk    (clk),
    .clrN   (clrN),
    .vpaN   (vpaN),
    .strobes(strobes),
    .eClk   (eClk),
    .vmaN   (vmaN)
  );
endmodule

// File: rtl/eclk_vma_gen_chk.sv
module eclk_vma_gen_chk #(
  parameter int LOW_CYCLES  = 6,
  parameter int HIGH_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic asN,
  input logic vpaN,
  input logic eClk,
  input logic vmaN
);
  logic        active;
  logic [15:0] highRun;
  logic [15:0] lowRun;

  assign active = rstN & ~asN;

  always_ff @(posedge clk or negedge active) begin
    if (!active) begin
      highRun <= '0;
      lowRun  <= '0;
    end else begin
      highRun <= eClk ? ((highRun == 16'hFFFF) ? highRun : highRun + 1'b1) : '0;
      lowRun  <= eClk ? '0 : ((lowRun == 16'hFFFF) ? lowRun : lowRun + 1'b1);
    end
  end

  // R1 R2 R7
  always @(negedge clk) begin
    if (!rstN || asN) begin
      cleared_outputs_chk: assert (!eClk && vmaN);
    end
  end

  // R3
  always @(negedge clk) begin
    if (active) begin
      e_high_len_chk: assert (highRun <= 16'(HIGH_CYCLES));
      e_low_len_chk:  assert (lowRun  <= 16'(LOW_CYCLES));
    end
  end

  // R5
  vma_ends_with_e_chk: assert property (@(posedge clk) disable iff (!active)
    $fell(eClk) |-> vmaN);

  // R5
  vma_starts_in_low_chk: assert property (@(posedge clk) disable iff (!active)
    $fell(vmaN) |-> !eClk);

  // R6
  vma_needs_request_chk: assert property (@(posedge clk) disable iff (!active)
    $fell(vmaN) |-> $past(!vpaN));
endmodule

bind eclk_vma_gen eclk_vma_gen_chk #(
  .LOW_CYCLES (LOW_CYCLES),
  .HIGH_CYCLES(HIGH_CYCLES)
) chk (
  .clk (clk),
  .rstN(rstN),
  .asN (asN),
  .vpaN(vpaN),
  .eClk(eClk),
  .vmaN(vmaN)
);

// File: tb/eclk_vma_gen_test.sv
module eclk_vma_gen_test;
  logic clk = 1'b0;
  logic rstN, asN, vpaN;
  logic eClk, vmaN;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  eclk_vma_gen uut (
    .clk (clk),
    .rstN(rstN),
    .asN (asN),
    .vpaN(vpaN),
    .eClk(eClk),
    .vmaN(vmaN)
  );

  // Per period: vpaN level before edges 1..10 (bit k-1 = edge k), then vmaN-low expected.
  localparam logic [10:0] PATTERNS [4] = '{
    {10'h000, 1'b1},   // request held low
    {10'h3FF, 1'b0},   // request held high
    {10'h004, 1'b0},   // high only at the sampling edge
    {10'h3FB, 1'b1}    // low only at the sampling edge
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {eClk,vmaN} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edgeStep();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; asN = 1'b0; vpaN = 1'b0;
    repeat (3) edgeStep();
    // R1: reset holds outputs even with strobe and request active
    check("R1", {eClk, vmaN}, 2'b01);
    rstN = 1'b1; asN = 1'b1;
    repeat (4) edgeStep();
    // R2: strobe negated keeps outputs cleared
    check("R2", {eClk, vmaN}, 2'b01);

    // Table walk: four consecutive periods with asN held low (R3 R4 R5 R6 R8)
    asN = 1'b0;
    foreach (PATTERNS[p]) begin
      for (int k = 1; k <= 10; k++) begin
        logic expE, expV;
        vpaN = PATTERNS[p][k];
        edgeStep();
        expE = (k >= 6) && (k <= 9);
        expV = !(PATTERNS[p][0] && (k >= 3) && (k <= 9));
        check(p == 0 ? "R3" : (p == 1 ? "R6" : (p == 3 ? "R8" : "R5")), {eClk, vmaN}, {expE, expV});
      end
    end

    // R7: strobe negated during E high with VMA asserted
    vpaN = 1'b0;
    repeat (7) edgeStep();
    check("R5", {eClk, vmaN}, 2'b10);
    asN = 1'b1;
    #0.5;
    check("R7", {eClk, vmaN}, 2'b01);
    edgeStep();

    // R4: restart alignment after strobe toggles
    asN = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      edgeStep();
      check("R4", {eClk, vmaN}, {(k >= 6), !(k >= 3)});
    end

    // R2: asynchronous clear inside a period, then restart
    asN = 1'b1;
    #0.5;
    check("R2", {eClk, vmaN}, 2'b01);
    edgeStep();
    asN = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      edgeStep();
      if (k == 5 || k == 6 || k == 10)
        check("R4", eClk ? {1'b1, vmaN} : {1'b0, vmaN}, {(k == 6), (k == 10)});
    end

    // R1: asynchronous reset mid-period
    repeat (7) edgeStep();
    rstN = 1'b0;
    #0.5;
    check("R1", {eClk, vmaN}, 2'b01);
    edgeStep();
    check("R1", {eClk, vmaN}, 2'b01);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule